// File: doc/BRIEF.md
# Time-Multiplexed Residue Digit Multiply-Accumulate

This block is one residue digit lane of a dot-product engine built on a residue number system. It takes a stream of residue operand pairs, multiplies each pair, reduces the product under the modulus chosen by a set index, and accumulates the reduced products. The accumulation is exact and stays inside the range 0 to m-1 of the chosen modulus. Digits never exchange carries, so one datapath can be shared in time across several moduli. Each modulus keeps its own accumulator register. The only logic that differs between moduli is a small reduction table in the accumulator feedback path and the constant used by the product reduction.

Every operand pair arrives with a set index, a start-of-vector flag and an end-of-vector flag. Start-of-vector discards the old accumulator value of that set. End-of-vector makes the block return the finished residue together with its set index. Operands for any set can be fed on any cycle, one pair per cycle, and the sets can be freely interleaved. Higher precision is reached by running more sets through the same lane, not by adding lanes. Conversion to and from binary, and control at the matrix level, are outside the block.

Top module: `rns_digit_mac`

## Requirements
- R1: While reset is asserted and after it is released, result_valid_o is 0 and result_o is 0 until an operation with end-of-vector completes.
- R2: For a vector of operand pairs on set s, the reported result equals (sum of a*b) mod m_s. The moduli are m_0=61, m_1=59, m_2=53 and m_3=47, selected by set_i values 0 to 3. Operands must lie below the modulus of their set.
- R3: Every reported result lies in the range 0 to m_s-1 for its set s.
- R4: An operand pair accepted with valid_i=1 and eov_i=1 in cycle t makes result_valid_o high for exactly cycle t+2, with result_set_o equal to the set index of that pair.
- R5: An operand pair with sov_i=1 loads its set's accumulator with its own reduced product. Anything accumulated earlier for that set is discarded, even when that earlier vector never saw an end-of-vector.
- R6: The four sets keep separate accumulators. Pairs for different sets may be interleaved in any order, back to back, one per cycle, and each set still gets its own correct result.
- R7: A cycle with valid_i=0 changes no accumulator and produces no result, whatever a_i, b_i, set_i, sov_i and eov_i carry.
- R8: A valid pair with eov_i=0 produces no result pulse two cycles later.
- R9: A pair with both sov_i=1 and eov_i=1 reports a*b mod m_s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair present this cycle |
| set_i | input | 2 | Set index choosing the modulus and its accumulator |
| sov_i | input | 1 | First pair of a vector |
| eov_i | input | 1 | Last pair of a vector |
| a_i | input | 6 | First residue operand |
| b_i | input | 6 | Second residue operand |
| result_valid_o | output | 1 | One-cycle pulse carrying a finished residue |
| result_set_o | output | 2 | Set index of the finished residue |
| result_o | output | 6 | Finished residue |

## Verification
A pair driven in cycle t passes through the reduce register and then the accumulate register. Its result, or the lack of one, appears at the ports in cycle t+2. The bench drives the inputs on falling edges and keeps a two-entry delay line of the expected outcomes computed by its arithmetic model. On each falling edge it compares the ports against the entry that was driven two falling edges earlier. Because of this alignment, the presence, set index and value of every result are checked in exactly the cycle they are due, and every other cycle is checked for the absence of a pulse.

// File: rtl/rns_mac_pkg.sv
package rns_mac_pkg;
  localparam int NUM_SETS = 4;
  localparam int RES_W    = 6;
  localparam int SET_W    = $clog2(NUM_SETS);
  // each modulus must exceed 2**(RES_W-1) for the fold bound to hold
  localparam int MODULI [NUM_SETS] = '{61, 59, 53, 47};
  localparam int FOLDS    = 5;

  typedef struct packed {
    logic             valid;
    logic [SET_W-1:0] set;
    logic             sov;
    logic             eov;
    logic [RES_W-1:0] prod;
  } red_t;

  function automatic int mod_of(input logic [SET_W-1:0] s);
    return MODULI[int'(s)];
  endfunction
endpackage

// File: rtl/rns_prod_reduce.sv
module rns_prod_reduce
  import rns_mac_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SET_W-1:0] set_i,
  input  logic             sov_i,
  input  logic             eov_i,
  input  logic [RES_W-1:0] a_i,
  input  logic [RES_W-1:0] b_i,
  output red_t             red_o
);
  localparam int PW = 2 * RES_W;

  logic [PW-1:0]    prod;
  logic [RES_W-1:0] cand [NUM_SETS];
  red_t             red_q;

  assign prod = {{RES_W{1'b0}}, a_i} * {{RES_W{1'b0}}, b_i};

  // multiply-free reduction: 2**RES_W == C (mod M), fold high part by constant C
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_red
    localparam int M = MODULI[s];
    localparam logic [PW-1:0] C  = PW'((1 << RES_W) - M);
    localparam logic [PW-1:0] MV = PW'(M);
    always_comb begin
      logic [PW-1:0] t;
      t = prod;
      for (int i = 0; i < FOLDS; i++)
        t = {{RES_W{1'b0}}, t[RES_W-1:0]} + ({{RES_W{1'b0}}, t[PW-1:RES_W]} * C);
      if (t >= MV) t = t - MV;
      if (t >= MV) t = t - MV;
      cand[s] = t[RES_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) red_q <= '0;
    else         red_q <= '{valid: valid_i, set: set_i, sov: sov_i, eov: eov_i, prod: cand[set_i]};
  end

  assign red_o = red_q;

  // R3
  red_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    red_q.valid |-> int'(red_q.prod) < mod_of(red_q.set));
endmodule

// File: rtl/rns_acc_bank.sv
module rns_acc_bank
  import rns_mac_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  red_t             red_i,
  output logic             res_valid_o,
  output logic [SET_W-1:0] res_set_o,
  output logic [RES_W-1:0] res_o
);
  localparam int LUT_D = 2 ** (RES_W + 1);

  logic [RES_W-1:0] acc_q [NUM_SETS];
  logic [RES_W-1:0] lut   [NUM_SETS][LUT_D];
  logic [RES_W-1:0] base;
  logic [RES_W:0]   sum;
  logic [RES_W-1:0] nxt;

  // feedback reduction tables: the only per-modulus state-free logic
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_lut
    for (genvar e = 0; e < LUT_D; e++) begin : g_ent
      localparam int V = e % MODULI[s];
      assign lut[s][e] = RES_W'(V);
    end
  end

  assign base = red_i.sov ? '0 : acc_q[red_i.set];
  assign sum  = {1'b0, base} + {1'b0, red_i.prod};
  assign nxt  = lut[red_i.set][sum];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) acc_q[s] <= '0;
      res_valid_o <= 1'b0;
      res_set_o   <= '0;
      res_o       <= '0;
    end else begin
      res_valid_o <= red_i.valid & red_i.eov;
      if (red_i.valid) acc_q[red_i.set] <= nxt;
      if (red_i.valid && red_i.eov) begin
        res_set_o <= red_i.set;
        res_o     <= nxt;
      end
    end
  end

  // R2
  sum_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    red_i.valid |-> int'(sum) < 2 * mod_of(red_i.set));

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_hold
    // R6
    acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(red_i.valid && red_i.set == SET_W'(s)) |=> $stable(acc_q[s]));
  end
endmodule

// File: rtl/rns_digit_mac.sv
module rns_digit_mac
  import rns_mac_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       set_i,
  input  logic             sov_i,
  input  logic             eov_i,
  input  logic [5:0]       a_i,
  input  logic [5:0]       b_i,
  output logic             result_valid_o,
  output logic [1:0]       result_set_o,
  output logic [5:0]       result_o
);
  red_t red;

  rns_prod_reduce u_reduce (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .set_i   (set_i),
    .sov_i   (sov_i),
    .eov_i   (eov_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .red_o   (red)
  );

  rns_acc_bank u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .red_i       (red),
    .res_valid_o (result_valid_o),
    .res_set_o   (result_set_o),
    .res_o       (result_o)
  );

  int single_exp;
  assign single_exp = (int'(a_i) * int'(b_i)) % mod_of(set_i);

  // R4
  result_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && eov_i) |=> ##1 (result_valid_o && result_set_o == $past(set_i, 2)));

  // R8
  no_spurious_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && eov_i) |=> ##1 !result_valid_o);

  // R9
  single_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sov_i && eov_i) |=> ##1 (int'(result_o) == $past(single_exp, 2)));

  // R3
  result_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> int'(result_o) < mod_of(result_set_o));
endmodule

// File: tb/rns_digit_mac_tb.sv
`timescale 1ns/1ps
module rns_digit_mac_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [1:0] set_i = '0;
  logic       sov_i = 1'b0;
  logic       eov_i = 1'b0;
  logic [5:0] a_i = '0;
  logic [5:0] b_i = '0;
  logic       result_valid_o;
  logic [1:0] result_set_o;
  logic [5:0] result_o;

  int tests = 0;
  int fails = 0;
  int mods [4] = '{61, 59, 53, 47};
  int acc_m [4] = '{0, 0, 0, 0};
  bit open_v [4] = '{0, 0, 0, 0};

  logic p1_v = 0, p1_e = 0, p2_v = 0, p2_e = 0;
  int p1_s = 0, p1_val = 0, p2_s = 0, p2_val = 0;
  string p1_tag = "R7", p2_tag = "R7";

  always #5 clk_i = ~clk_i;

  rns_digit_mac u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .set_i(set_i),
    .sov_i(sov_i), .eov_i(eov_i), .a_i(a_i), .b_i(b_i),
    .result_valid_o(result_valid_o), .result_set_o(result_set_o), .result_o(result_o)
  );

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_out();
    if (p2_v && p2_e) begin
      check("R4", result_valid_o === 1'b1, int'(result_valid_o), 1);
      check("R4", result_set_o === 2'(p2_s), int'(result_set_o), p2_s);
      check(p2_tag, int'(result_o) == p2_val, int'(result_o), p2_val);
      check("R3", int'(result_o) < mods[p2_s], int'(result_o), mods[p2_s] - 1);
    end else begin
      check(p2_v ? "R8" : "R7", result_valid_o === 1'b0, int'(result_valid_o), 0);
    end
  endtask

  task automatic step(input bit v, input int s, input int a, input int b,
                      input bit sov, input bit eov, input string tag);
    int prod;
    @(negedge clk_i);
    compare_out();
    p2_v = p1_v; p2_e = p1_e; p2_s = p1_s; p2_val = p1_val; p2_tag = p1_tag;
    valid_i = v; set_i = 2'(s); a_i = 6'(a); b_i = 6'(b); sov_i = sov; eov_i = eov;
    if (v) begin
      prod = (a * b) % mods[s];
      acc_m[s] = sov ? prod : (acc_m[s] + prod) % mods[s];
    end
    p1_v = v; p1_e = eov; p1_s = s; p1_val = acc_m[s]; p1_tag = tag;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", result_valid_o === 1'b0, int'(result_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", result_valid_o === 1'b0 && result_o === 6'd0, int'(result_o), 0);

    // R9: exhaustive single-term vectors per set
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < mods[s]; a++)
        for (int b = 0; b < mods[s]; b++)
          step(1, s, a, b, 1, 1, "R9");

    // R2: long vectors of maximum residues, back to back on one set
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 20; k++)
        step(1, s, mods[s] - 1, mods[s] - 1, k == 0, k == 19, "R2");

    // R5: abandoned vector then restart on set 1
    for (int k = 0; k < 5; k++) step(1, 1, 30 + k, 40, k == 0, 0, "R5");
    for (int k = 0; k < 3; k++) step(1, 1, 7 + k, 11, k == 0, k == 2, "R5");

    // R7: idle cycles with junk on the other inputs mid-vector
    step(1, 2, 12, 13, 1, 0, "R7");
    for (int k = 0; k < 4; k++) step(0, 2, 50, 51, 1, 1, "R7");
    step(1, 2, 20, 21, 0, 1, "R7");

    // R6: random interleaving across sets
    for (int k = 0; k < 4000; k++) begin
      int s;
      bit e;
      if ($urandom % 8 == 0) step(0, int'($urandom % 4), 63, 63, 1, 1, "R7");
      else begin
        s = int'($urandom % 4);
        e = ($urandom % 5) == 0;
        step(1, s, int'($urandom % mods[s]), int'($urandom % mods[s]), !open_v[s], e, "R6");
        open_v[s] = !e;
      end
    end
    for (int s = 0; s < 4; s++)
      if (open_v[s]) step(1, s, 1, 1, 0, 1, "R6");

    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 0, "R7");
    finish_run();
  end
endmodule